// File: doc/BRIEF.md
# Trapezoidal Quasi-BLDC Gate Generator

This block drives the six switches of a three-phase inverter bridge for a brushless motor, so that each phase sees a trapezoidal voltage edge in place of a hard rectangular one. A controller supplies the commutation step (0 to 5) and a one-cycle commutate strobe at each 60-electrical-degree boundary. The block then moves the conduction window to the next gate pair. The gate that is switching on is pulse-width modulated by comparing a rising reference against a triangular carrier. The gate on the same side of the bridge that is switching off is driven as the logical inverse of the incoming gate. This keeps exactly one switch per bridge side conducting while the current moves from one phase to the next.

The reference rises linearly from zero over a number of carrier periods that is latched at each strobe. Once that ramp is complete, the incoming gate is held fully on until the next strobe. A small state machine has three states: IDLE (all gates off), RAMP (transition in progress) and HOLD (steady conduction). Its transitions are:
- IDLE→RAMP: a strobe arrives with a non-zero ramp length.
- IDLE→HOLD or RAMP/HOLD→HOLD: a strobe arrives with a zero ramp length.
- RAMP→RAMP or HOLD→RAMP: a strobe arrives with a non-zero ramp length, which restarts the ramp.
- RAMP→HOLD: the last ramp period ends.
- Any state→IDLE: the enable input is low.

Top module: `qbldc_gate_gen`

## Requirements
- R1: While reset is asserted, all six gate outputs are low. After reset, with the block enabled but before any accepted strobe, all outputs stay low. If enable is low at a clock edge, all outputs are low from that edge onward.
- R2: Bit k of gate_o is the k-th gate of the firing order: 0 A-high, 1 C-low, 2 B-high, 3 A-low, 4 C-high, 5 B-low. In step s, bit s is the incoming gate and bit (s+5) mod 6 is the held gate. The held gate is fully on throughout the step. No bit outside these two and the outgoing bit is ever high.
- R3: The carrier is an 8-bit triangle that restarts at 0 (rising) on each accepted strobe. It counts 0,1,…,255,254,…,1 and then repeats, giving a period of 510 clocks.
- R4: In ramp period p (0 ≤ p < L, where L is the latched ramp length), the incoming gate is high in each cycle where carrier·L < p·256. The clock edge that ends period L−1 moves the block to HOLD, and the incoming gate is then high continuously.
- R5: During a ramp that follows another step, the outgoing bit (s+4) mod 6 is the inverse of the incoming bit, so at most one high-side and one low-side gate are on at any time.
- R6: On the first strobe after IDLE, the outgoing bit stays low for the whole ramp.
- R7: A strobe with a ramp length of 0 makes the incoming gate fully on from the cycle that follows.
- R8: A strobe with a step value of 6 or 7 is ignored, and the gate outputs continue unchanged.
- R9: The ramp length is sampled only at an accepted strobe. Changes to it during a ramp have no effect.
- R10: A strobe that arrives while enable is low is ignored, and the outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Drive enable; low forces all gates off |
| commutate_i | input | 1 | One-cycle strobe that moves to step_i |
| step_i | input | 3 | Commutation step, 0 to 5 |
| ramp_len_i | input | LEN_W (8) | Ramp length in carrier periods |
| gate_o | output | 6 | Gate drives in firing order |

## Verification
The main function is exercised by walking through all six steps in turn with ramp lengths of 1, 2, 3 and 4, plus a zero-length step. In each ramp period the bench counts the cycles in which the incoming gate is high and compares the count with the closed-form value from R4. This count separates a correct carrier shape and threshold from errors in carrier direction, scaling or period count. Each cycle, the outgoing gate is compared with the inverse of the incoming gate and the held gate is checked to be high, which detects a wrong bit mapping or a missing handoff. Directed cases cover:
- a fresh start from IDLE
- strobes with an invalid step
- strobes while disabled
- ramp-length changes in the middle of a ramp
- reset
- disable

// File: rtl/qbg_pkg.sv
package qbg_pkg;

    localparam int NUM_GATES = 6;
    localparam int STEP_W    = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAMP = 2'd1,
        ST_HOLD = 2'd2
    } qbg_state_e;

    // Reduce an index in 0..11 to 0..5.
    function automatic logic [STEP_W-1:0] wrap6(input logic [STEP_W:0] v);
        logic [STEP_W:0] r;
        r = (v >= 4'd6) ? (v - 4'd6) : v;
        return r[STEP_W-1:0];
    endfunction

endpackage

// File: rtl/qbg_carrier.sv
module qbg_carrier #(
    parameter int CAR_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    output logic [CAR_W-1:0] cnt_o,
    output logic             period_end_o
);
    localparam logic [CAR_W-1:0] CMAX = {CAR_W{1'b1}};
    localparam logic [CAR_W-1:0] ONE  = CAR_W'(1);

    logic [CAR_W-1:0] cnt_q;
    logic             up_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (restart_i) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (up_q) begin
            if (cnt_q == CMAX) begin
                up_q  <= 1'b0;
                cnt_q <= CMAX - ONE;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end else begin
            if (cnt_q == ONE) begin
                up_q  <= 1'b1;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign cnt_o        = cnt_q;
    assign period_end_o = !up_q && (cnt_q == ONE);

endmodule

// File: rtl/qbg_gate_map.sv
module qbg_gate_map
    import qbg_pkg::*;
(
    input  qbg_state_e              state_i,
    input  logic [STEP_W-1:0]       step_i,
    input  logic                    pwm_i,
    input  logic                    handoff_i,
    output logic [NUM_GATES-1:0]    gate_o
);
    logic [STEP_W-1:0] idx_new, idx_hold, idx_out;

    always_comb begin
        idx_new  = step_i;
        idx_hold = wrap6({1'b0, step_i} + 4'd5);
        idx_out  = wrap6({1'b0, step_i} + 4'd4);
        gate_o   = '0;
        unique case (state_i)
            ST_IDLE: gate_o = '0;
            ST_RAMP: begin
                gate_o[idx_new]  = pwm_i;
                gate_o[idx_hold] = 1'b1;
                gate_o[idx_out]  = handoff_i & ~pwm_i;
            end
            ST_HOLD: begin
                gate_o[idx_new]  = 1'b1;
                gate_o[idx_hold] = 1'b1;
            end
            default: gate_o = '0;
        endcase
    end

endmodule

// File: rtl/qbldc_gate_gen.sv
module qbldc_gate_gen
    import qbg_pkg::*;
#(
    parameter int CAR_W = 8,
    parameter int LEN_W = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 en_i,
    input  logic                 commutate_i,
    input  logic [2:0]           step_i,
    input  logic [LEN_W-1:0]     ramp_len_i,
    output logic [5:0]           gate_o
);
    localparam int PROD_W = CAR_W + LEN_W;

    qbg_state_e        state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic [LEN_W-1:0]  len_q, per_q;
    logic              handoff_q;
    logic              accept, period_end, pwm, last_period;
    logic [CAR_W-1:0]  car_cnt;
    logic [PROD_W-1:0] lhs, rhs;

    assign accept      = en_i && commutate_i && (step_i <= 3'd5);
    assign last_period = (per_q == (len_q - LEN_W'(1)));

    qbg_carrier #(.CAR_W(CAR_W)) u_carrier (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .restart_i    (accept),
        .cnt_o        (car_cnt),
        .period_end_o (period_end)
    );

    assign lhs = PROD_W'(car_cnt) * PROD_W'(len_q);
    assign rhs = PROD_W'(per_q) << CAR_W;
    assign pwm = lhs < rhs;

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else if (accept) begin
            state_d = (ramp_len_i == '0) ? ST_HOLD : ST_RAMP;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RAMP: if (period_end && last_period) state_d = ST_HOLD;
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            step_q    <= '0;
            len_q     <= '0;
            per_q     <= '0;
            handoff_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!en_i) begin
                handoff_q <= 1'b0;
            end else if (accept) begin
                step_q    <= step_i;
                len_q     <= ramp_len_i;
                per_q     <= '0;
                handoff_q <= (state_q != ST_IDLE);
            end else if (state_q == ST_RAMP && period_end) begin
                per_q <= per_q + LEN_W'(1);
            end
        end
    end

    qbg_gate_map u_map (
        .state_i   (state_q),
        .step_i    (step_q),
        .pwm_i     (pwm),
        .handoff_i (handoff_q),
        .gate_o    (gate_o)
    );

endmodule

// File: rtl/qbg_checker.sv
module qbg_checker #(
    parameter int LEN_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             commutate_i,
    input logic [2:0]       step_i,
    input logic [LEN_W-1:0] ramp_len_i,
    input logic [5:0]       gate_o
);
    AST_ONE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(gate_o & 6'b010101) <= 1); // R5
    AST_ONE_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(gate_o & 6'b101010) <= 1); // R5
    AST_TWO_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(gate_o) <= 2); // R2
    AST_DISABLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> gate_o == 6'b0); // R1
    AST_RAMP_STARTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && commutate_i && step_i <= 3'd5 && ramp_len_i != '0)
            |=> !gate_o[$past(step_i)]); // R4
    AST_ZERO_LEN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && commutate_i && step_i <= 3'd5 && ramp_len_i == '0)
            |=> gate_o[$past(step_i)]); // R7
endmodule

bind qbldc_gate_gen qbg_checker #(.LEN_W(LEN_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .commutate_i (commutate_i),
    .step_i      (step_i),
    .ramp_len_i  (ramp_len_i),
    .gate_o      (gate_o)
);

// File: tb/qbldc_gate_gen_tb_top.sv
`timescale 1ns/1ps
module qbldc_gate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       commutate = 1'b0;
    logic [2:0] step = 3'd0;
    logic [7:0] ramp_len = 8'd0;
    logic [5:0] gate;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    qbldc_gate_gen dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .en_i        (en),
        .commutate_i (commutate),
        .step_i      (step),
        .ramp_len_i  (ramp_len),
        .gate_o      (gate)
    );

    // step, ramp length, incoming mask, held mask, outgoing mask
    typedef struct packed {
        logic [2:0] stp;
        logic [7:0] len;
        logic [5:0] m_new;
        logic [5:0] m_hold;
        logic [5:0] m_out;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 8'd1, 6'b000001, 6'b100000, 6'b010000},
        '{3'd1, 8'd2, 6'b000010, 6'b000001, 6'b100000},
        '{3'd2, 8'd3, 6'b000100, 6'b000010, 6'b000001},
        '{3'd3, 8'd1, 6'b001000, 6'b000100, 6'b000010},
        '{3'd4, 8'd0, 6'b010000, 6'b001000, 6'b000100},
        '{3'd5, 8'd4, 6'b100000, 6'b010000, 6'b001000},
        '{3'd0, 8'd2, 6'b000001, 6'b100000, 6'b010000}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Cycles the incoming gate is high in ramp period p of length l
    function automatic int exp_on(input int p, input int l);
        int n, up_n, dn_n;
        n    = (p * 256 + l - 1) / l;
        up_n = (n > 256) ? 256 : n;
        dn_n = n - 1;
        if (dn_n < 0)   dn_n = 0;
        if (dn_n > 254) dn_n = 254;
        return up_n + dn_n;
    endfunction

    task automatic strobe(input logic [2:0] s, input logic [7:0] l);
        @(negedge clk);
        commutate = 1'b1;
        step      = s;
        ramp_len  = l;
        @(negedge clk);
        commutate = 1'b0;
        ramp_len  = 8'd9; // R9: mid-ramp change must not matter
    endtask

    task automatic run_ramp(input vec_t v, input bit fresh);
        int  l;
        bit  bad;
        int  on_cnt;
        l   = int'(v.len);
        bad = 1'b0;
        for (int p = 0; p < l; p++) begin
            on_cnt = 0;
            for (int k = 0; k < 510; k++) begin
                if ((gate & v.m_new) != 0) on_cnt++;
                if ((gate & v.m_hold) == 0) bad = 1'b1;
                if ((gate & ~(v.m_new | v.m_hold | v.m_out)) != 0) bad = 1'b1;
                if (fresh) begin
                    if ((gate & v.m_out) != 0) bad = 1'b1;
                end else if (((gate & v.m_out) != 0) == ((gate & v.m_new) != 0)) begin
                    bad = 1'b1;
                end
                @(negedge clk);
            end
            chk(on_cnt == exp_on(p, l), "R4 R3 period duty", on_cnt, exp_on(p, l));
        end
        if (l > 0)
            chk(!bad, fresh ? "R6 R2 ramp gates" : "R5 R2 ramp gates", int'(bad), 0);
        chk(gate == (v.m_new | v.m_hold), (l == 0) ? "R7 hold mask" : "R4 R9 hold mask",
            int'(gate), int'(v.m_new | v.m_hold));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] held;
        repeat (3) @(negedge clk);
        chk(gate == 6'b0, "R1 reset", int'(gate), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(gate == 6'b0, "R1 idle after reset", int'(gate), 0);

        // R10: strobe while disabled
        strobe(3'd0, 8'd0);
        chk(gate == 6'b0, "R10 disabled strobe", int'(gate), 0);
        en = 1'b1;
        repeat (2) @(negedge clk);
        chk(gate == 6'b0, "R10 R1 idle after enable", int'(gate), 0);

        // R6: fresh start from IDLE, step 5, one period
        strobe(3'd5, 8'd1);
        run_ramp('{3'd5, 8'd1, 6'b100000, 6'b010000, 6'b001000}, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            strobe(VECS[i].stp, VECS[i].len);
            run_ramp(VECS[i], 1'b0);
        end

        // R8: invalid step ignored while holding
        held = gate;
        strobe(3'd7, 8'd0);
        chk(gate == held, "R8 step 7 ignored", int'(gate), int'(held));
        strobe(3'd6, 8'd3);
        repeat (3) @(negedge clk);
        chk(gate == held, "R8 step 6 ignored", int'(gate), int'(held));

        // R1: disable forces all off
        en = 1'b0;
        @(negedge clk);
        chk(gate == 6'b0, "R1 disable", int'(gate), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule